// File: doc/BRIEF.md
# Reservation-Based Atomic Memory Monitor

This block is a small shared word memory served to several requesters. Atomicity comes from a two-step protocol instead of a locked read-modify-write. A requester first issues a linked load. That load returns the current word and records a reservation for that requester on that word address. Later the requester issues a conditional store. The store commits only if the reservation is still intact, and the requester learns the outcome from a 1 (success) or 0 (failure) in the response data. Any write to a reserved word in between, whether a plain store or another requester's successful conditional store, breaks the reservation.

Software builds a spin lock from this pair. It issues a linked load and retries while the word is non-zero. It then issues a conditional store of 1 and retries from the top whenever the result comes back 0. Each port has a request channel with valid/ready flow control. A request is offered by raising `req_valid`, and its fields must stay stable until `req_ready` is seen high at a clock edge. One request is accepted per cycle, and the lowest-numbered port wins. The response is a one-cycle pulse that cannot be stalled, so the requester must always be able to take it.

Top module: `llsc_monitor`

## Requirements
- R1: The word address of every operation is `req_base` plus `req_off` treated as a two's-complement number sign-extended to the address width, wrapping modulo the memory depth.
- R2: Operation codes are 2'b00 plain load, 2'b01 plain store, 2'b10 linked load and 2'b11 conditional store. A plain load returns the addressed word. A plain store writes `req_wdata`, and its response data is zero.
- R3: A linked load returns the addressed word and gives its port a reservation on that address. A port holds at most one reservation, and a newer linked load replaces the older one.
- R4: A conditional store whose port holds a valid reservation on the same address writes `req_wdata` and responds with data 1.
- R5: A conditional store without a valid reservation, or aimed at an address other than the reserved one, responds with data 0 and leaves memory unchanged.
- R6: A plain store from any port clears every reservation, on every port including its own, that matches its address.
- R7: A successful conditional store clears the reservations of all ports on that address.
- R8: Every conditional store clears its own port's reservation, whether it passes or fails.
- R9: Writes to other addresses leave a reservation intact, because comparison is by whole word address.
- R10: Each cycle at most one `req_ready` bit is high. It goes to the lowest-indexed port with `req_valid` high, and never to a port whose `req_valid` is low. A request that is not granted waits.
- R11: Exactly one cycle after acceptance, `rsp_valid` pulses for one cycle, only on the accepted port's bit, with the result on `rsp_data`.
- R12: Synchronous reset clears all memory words to zero and drops every reservation. While reset is high, `req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_PORTS | Request offered, one bit per port |
| req_ready | output | NUM_PORTS | Request accepted this cycle, one bit per port |
| req_op | input | NUM_PORTS x 2 | Operation code per port |
| req_base | input | NUM_PORTS x ADDR_W | Base word address per port |
| req_off | input | NUM_PORTS x OFF_W | Signed word offset per port |
| req_wdata | input | NUM_PORTS x DATA_W | Store data per port |
| rsp_valid | output | NUM_PORTS | Response pulse, one bit per port |
| rsp_data | output | DATA_W | Read word, conditional-store result, or zero |

## Verification
On every cycle, the assertions check the grant rules, the timing of the response pulse, the shape of conditional-store and plain-store responses, and the bookkeeping in the reservation table. That bookkeeping covers a linked load setting its port's entry and a plain store clearing every matching entry. Whether a conditional store should pass depends on the history of interleaved operations from other ports, so only the bench's scenarios can show it. Those scenarios cover an intervening store, a competing successful conditional store, a replaced reservation, a failed attempt that consumes the reservation, and wrapped offset arithmetic. The bench's reference model follows every accepted request and checks the memory contents through later loads.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LINK  = 2'b10,
    OP_COND  = 2'b11
  } mem_op_e;
endpackage

// File: rtl/llsc_arbiter.sv
module llsc_arbiter #(
  parameter int NUM_PORTS = 3
) (
  input  logic [NUM_PORTS-1:0] req,
  output logic [NUM_PORTS-1:0] gnt
);
  logic [NUM_PORTS:0] blocked;
  assign blocked[0] = 1'b0;
  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chain
    assign gnt[i]       = req[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | req[i];
  end
endmodule

// File: rtl/llsc_addr_gen.sv
module llsc_addr_gen #(
  parameter int ADDR_W = 6,
  parameter int OFF_W  = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] addr
);
  localparam int EXT_W = ADDR_W - OFF_W;
  logic [ADDR_W-1:0] off_ext;
  assign off_ext = {{EXT_W{off[OFF_W-1]}}, off};
  assign addr    = base + off_ext;
endmodule

// File: rtl/llsc_resv_table.sv
module llsc_resv_table
  import llsc_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int ADDR_W    = 6,
  localparam int PW       = $clog2(NUM_PORTS)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           op_valid,
  input  logic [PW-1:0]                  op_port,
  input  mem_op_e                        op,
  input  logic [ADDR_W-1:0]              op_addr,
  output logic                           sc_pass,
  output logic [NUM_PORTS-1:0]           res_v,
  output logic [NUM_PORTS-1:0][ADDR_W-1:0] res_a
);
  logic writes_word;

  assign sc_pass     = res_v[op_port] && (res_a[op_port] == op_addr);
  assign writes_word = (op == OP_STORE) || ((op == OP_COND) && sc_pass);

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_entry
    logic own;
    assign own = (op_port == PW'(i));
    always_ff @(posedge clk) begin
      if (rst) begin
        res_v[i] <= 1'b0;
        res_a[i] <= '0;
      end else if (op_valid) begin
        if (own && op == OP_LINK) begin
          res_v[i] <= 1'b1;
          res_a[i] <= op_addr;
        end else if (own && op == OP_COND) begin
          res_v[i] <= 1'b0;
        end else if (writes_word && res_v[i] && res_a[i] == op_addr) begin
          res_v[i] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int ADDR_W    = 6,
  parameter int OFF_W     = 4,
  parameter int DATA_W    = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_PORTS-1:0]              req_valid,
  output logic [NUM_PORTS-1:0]              req_ready,
  input  logic [NUM_PORTS-1:0][1:0]         req_op,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  req_base,
  input  logic [NUM_PORTS-1:0][OFF_W-1:0]   req_off,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]  req_wdata,
  output logic [NUM_PORTS-1:0]              rsp_valid,
  output logic [DATA_W-1:0]                 rsp_data
);
  localparam int PW    = $clog2(NUM_PORTS);
  localparam int DEPTH = 1 << ADDR_W;

  logic [NUM_PORTS-1:0]             gnt;
  logic                             any_gnt;
  logic [PW-1:0]                    sel_idx;
  mem_op_e                          sel_op;
  logic [ADDR_W-1:0]                sel_addr;
  logic                             sc_pass;
  logic                             do_write;
  logic [NUM_PORTS-1:0]             res_v;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] res_a;
  logic [DATA_W-1:0]                mem [DEPTH];

  llsc_arbiter #(.NUM_PORTS(NUM_PORTS)) u_arb (
    .req (req_valid & {NUM_PORTS{~rst}}),
    .gnt (gnt)
  );

  assign req_ready = gnt;
  assign any_gnt   = |gnt;

  always_comb begin
    sel_idx = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (gnt[i]) sel_idx = PW'(i);
    end
  end

  assign sel_op = mem_op_e'(req_op[sel_idx]);

  llsc_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ea (
    .base (req_base[sel_idx]),
    .off  (req_off[sel_idx]),
    .addr (sel_addr)
  );

  llsc_resv_table #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_resv (
    .clk      (clk),
    .rst      (rst),
    .op_valid (any_gnt),
    .op_port  (sel_idx),
    .op       (sel_op),
    .op_addr  (sel_addr),
    .sc_pass  (sc_pass),
    .res_v    (res_v),
    .res_a    (res_a)
  );

  assign do_write = any_gnt && ((sel_op == OP_STORE) || (sel_op == OP_COND && sc_pass));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
    end else if (do_write) begin
      mem[sel_addr] <= req_wdata[sel_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= gnt;
      if (any_gnt) begin
        unique case (sel_op)
          OP_LOAD, OP_LINK: rsp_data <= mem[sel_addr];
          OP_COND:          rsp_data <= DATA_W'(sc_pass);
          default:          rsp_data <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk
  import llsc_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32
) (
  input logic                              clk,
  input logic                              rst,
  input logic [NUM_PORTS-1:0]              req_valid,
  input logic [NUM_PORTS-1:0]              req_ready,
  input logic [NUM_PORTS-1:0]              rsp_valid,
  input logic [DATA_W-1:0]                 rsp_data,
  input mem_op_e                           sel_op,
  input logic [ADDR_W-1:0]                 sel_addr,
  input logic [NUM_PORTS-1:0]              res_v,
  input logic [NUM_PORTS-1:0][ADDR_W-1:0]  res_a
);
  // R10
  one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_ready));

  // R10
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (req_ready & ~req_valid) == '0);

  // R11
  rsp_follows_grant_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid == $past(req_ready));

  // R4
  sc_result_binary_chk: assert property (@(posedge clk) disable iff (rst)
    (|req_ready && sel_op == OP_COND) |=> (rsp_data >> 1) == '0);

  // R2
  store_rsp_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (|req_ready && sel_op == OP_STORE) |=> rsp_data == '0);

  for (genvar j = 0; j < NUM_PORTS; j++) begin : g_port
    // R6
    store_clears_chk: assert property (@(posedge clk) disable iff (rst)
      (|req_ready && sel_op == OP_STORE && res_v[j] && res_a[j] == sel_addr)
      |=> !res_v[j]);

    // R3
    link_sets_chk: assert property (@(posedge clk) disable iff (rst)
      (req_ready[j] && sel_op == OP_LINK)
      |=> (res_v[j] && res_a[j] == $past(sel_addr)));

    // R8
    cond_drops_own_chk: assert property (@(posedge clk) disable iff (rst)
      (req_ready[j] && sel_op == OP_COND) |=> !res_v[j]);
  end
endmodule

bind llsc_monitor llsc_monitor_chk #(
  .NUM_PORTS (NUM_PORTS),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .sel_op    (sel_op),
  .sel_addr  (sel_addr),
  .res_v     (res_v),
  .res_a     (res_a)
);

// File: tb/llsc_monitor_bench.sv
`timescale 1ns/1ps
module llsc_monitor_bench;
  localparam int N  = 3;
  localparam int AW = 6;
  localparam int OW = 4;
  localparam int DW = 32;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]          req_valid = '0;
  logic [N-1:0]          req_ready;
  logic [N-1:0][1:0]     req_op    = '0;
  logic [N-1:0][AW-1:0]  req_base  = '0;
  logic [N-1:0][OW-1:0]  req_off   = '0;
  logic [N-1:0][DW-1:0]  req_wdata = '0;
  logic [N-1:0]          rsp_valid;
  logic [DW-1:0]         rsp_data;

  always #4 clk = ~clk;

  llsc_monitor #(.NUM_PORTS(N), .ADDR_W(AW), .OFF_W(OW), .DATA_W(DW)) u_llsc_monitor (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_base(req_base), .req_off(req_off), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  int nchk = 0;
  int nfail = 0;
  string ctx = "";

  logic [DW-1:0] mdl_mem [DEPTH];
  bit            mdl_rv  [N];
  logic [AW-1:0] mdl_ra  [N];
  logic [N-1:0]  exp_rv = '0;
  logic [DW-1:0] exp_data = '0;
  string         exp_tag = "";

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, ctx, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] word_of(logic [AW-1:0] b, logic [OW-1:0] o);
    int s;
    s = int'(b) + int'($signed(o));
    return AW'(s & (DEPTH - 1));
  endfunction

  // One clock: model the grant, then check the response at the next negedge.
  task automatic step();
    int w;
    logic [N-1:0] drop;
    logic [AW-1:0] a;
    bit ok;
    #1;
    w = -1;
    for (int i = N - 1; i >= 0; i--) if (req_valid[i]) w = i;
    drop = '0;
    if (w >= 0) drop[w] = 1'b1;
    chk("R10 ready", 64'(req_ready), 64'(drop));
    exp_rv = drop;
    if (w >= 0) begin
      a = word_of(req_base[w], req_off[w]);
      case (req_op[w])
        2'b00: begin exp_data = mdl_mem[a]; exp_tag = "R2 load"; end
        2'b01: begin
          exp_data = '0; exp_tag = "R2 store";
          mdl_mem[a] = req_wdata[w];
          for (int j = 0; j < N; j++) if (mdl_rv[j] && mdl_ra[j] == a) mdl_rv[j] = 0;
        end
        2'b10: begin
          exp_data = mdl_mem[a]; exp_tag = "R3 link";
          mdl_rv[w] = 1; mdl_ra[w] = a;
        end
        default: begin
          ok = mdl_rv[w] && mdl_ra[w] == a;
          mdl_rv[w] = 0;
          exp_data = DW'(ok);
          exp_tag = ok ? "R4 cond-pass" : "R5 cond-fail";
          if (ok) begin
            mdl_mem[a] = req_wdata[w];
            for (int j = 0; j < N; j++) if (mdl_rv[j] && mdl_ra[j] == a) mdl_rv[j] = 0;
          end
        end
      endcase
    end
    @(negedge clk);
    req_valid = req_valid & ~drop;
    chk("R11 rsp_valid", 64'(rsp_valid), 64'(exp_rv));
    if (exp_rv != '0) chk(exp_tag, 64'(rsp_data), 64'(exp_data));
  endtask

  task automatic post(int p, logic [1:0] op, logic [AW-1:0] b, logic [OW-1:0] o, logic [DW-1:0] d);
    req_valid[p] = 1'b1;
    req_op[p]    = op;
    req_base[p]  = b;
    req_off[p]   = o;
    req_wdata[p] = d;
  endtask

  task automatic drain();
    while (req_valid != '0) step();
  endtask

  task automatic one(int p, logic [1:0] op, logic [AW-1:0] b, logic [OW-1:0] o, logic [DW-1:0] d);
    post(p, op, b, o, d);
    drain();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl_mem[i] = '0;
    for (int i = 0; i < N; i++) begin mdl_rv[i] = 0; mdl_ra[i] = '0; end
    // R12: ready held low during reset even with a request offered
    req_valid[0] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 ready in reset", 64'(req_ready), 64'(0));
    chk("R12 rsp in reset", 64'(rsp_valid), 64'(0));
    req_valid = '0;
    rst = 1'b0;
    @(negedge clk);

    ctx = "R12 memory cleared";
    one(0, 2'b00, 6'd5, 4'd0, '0);
    one(2, 2'b00, 6'd63, 4'd0, '0);

    ctx = "R1 negative offset wraps";
    one(0, 2'b01, 6'd2, 4'hD, 32'hA5A5_0001);   // word 63
    one(1, 2'b00, 6'd60, 4'd3, '0);             // word 63
    one(2, 2'b00, 6'd62, 4'd1, '0);
    ctx = "R1 positive wrap";
    one(1, 2'b01, 6'd61, 4'd7, 32'h0000_BEEF);  // word 4
    one(0, 2'b00, 6'd4, 4'd0, '0);

    ctx = "R4 link then cond";
    one(0, 2'b10, 6'd10, 4'd0, '0);
    one(0, 2'b11, 6'd8, 4'd2, 32'h1);
    one(1, 2'b00, 6'd10, 4'd0, '0);

    ctx = "R5 cond without link";
    one(1, 2'b11, 6'd11, 4'd0, 32'h77);
    one(1, 2'b00, 6'd11, 4'd0, '0);

    ctx = "R6 store breaks reservation";
    one(0, 2'b10, 6'd12, 4'd0, '0);
    one(1, 2'b01, 6'd12, 4'd0, 32'h3);
    one(0, 2'b11, 6'd12, 4'd0, 32'h9);
    one(2, 2'b00, 6'd12, 4'd0, '0);
    ctx = "R6 own store breaks reservation";
    one(2, 2'b10, 6'd13, 4'd0, '0);
    one(2, 2'b01, 6'd13, 4'd0, 32'h4);
    one(2, 2'b11, 6'd13, 4'd0, 32'h5);

    ctx = "R7 competing cond";
    one(0, 2'b10, 6'd20, 4'd0, '0);
    one(1, 2'b10, 6'd20, 4'd0, '0);
    one(1, 2'b11, 6'd20, 4'd0, 32'h11);
    one(0, 2'b11, 6'd20, 4'd0, 32'h22);
    one(2, 2'b00, 6'd20, 4'd0, '0);

    ctx = "R3 replaced reservation";
    one(0, 2'b10, 6'd21, 4'd0, '0);
    one(0, 2'b10, 6'd22, 4'd0, '0);
    one(0, 2'b11, 6'd21, 4'd0, 32'h55);
    one(1, 2'b00, 6'd21, 4'd0, '0);

    ctx = "R8 failed cond consumes";
    one(1, 2'b10, 6'd24, 4'd0, '0);
    one(1, 2'b11, 6'd25, 4'd0, 32'h66);
    one(1, 2'b11, 6'd24, 4'd0, 32'h67);

    ctx = "R9 other word untouched";
    one(2, 2'b10, 6'd30, 4'd0, '0);
    one(0, 2'b01, 6'd31, 4'd0, 32'h88);
    one(1, 2'b11, 6'd29, 4'd0, 32'h89);
    one(2, 2'b11, 6'd30, 4'd0, 32'h1);

    ctx = "R10 contention";
    post(2, 2'b00, 6'd30, 4'd0, '0);
    post(1, 2'b10, 6'd40, 4'd0, '0);
    post(0, 2'b01, 6'd40, 4'd0, 32'hC0DE);
    drain();
    one(1, 2'b11, 6'd40, 4'd0, 32'h5);

    ctx = "R4 random mix";
    for (int it = 0; it < 400; it++) begin
      for (int p = 0; p < N; p++) begin
        if (!req_valid[p] && ($urandom_range(0, 2) != 0)) begin
          logic [OW-1:0] o;
          o = ($urandom_range(0, 2) == 0) ? 4'hF : OW'($urandom_range(0, 1));
          post(p, 2'($urandom_range(0, 3)), AW'($urandom_range(1, 3)), o, DW'($urandom));
        end
      end
      step();
    end
    drain();
    step();

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule